// File: doc/BRIEF.md
# Listen-Before-Talk Backoff Controller

This block holds back a transmit request until the radio channel has been quiet for long enough. A request is taken only while the received-signal-strength reading is valid, and only from the idle state. The block then listens. Once carrier sense drops, it counts a fixed listen window of ten timebase ticks (5 ms at one tick per 0.5 ms). After that it counts an extra number of tick slots, between 0 and 10. When the whole count ends with the channel still quiet, the block emits a single-cycle transmit-start pulse.

The extra slot count comes from a free-running linear feedback shift register. When the random enable input is low, the extra count is a fixed 5 slots (2.5 ms). The clear-channel output is simply the inverse of carrier sense. It therefore rises as soon as the channel goes quiet, well before the backoff ends. If carrier returns during the countdown, the countdown is dropped. A full new wait begins the next time the channel clears.

Top module: `lbt_backoff`

## Requirements
- R1: `clear_o` is always the inverse of `cs_i`, including while a backoff is counting.
- R2: `tx_req_i` is accepted only in idle with `rssi_ok_i` = 1. With `rssi_ok_i` = 0 the request is ignored: `busy_o` stays 0 and no `tx_start_o` follows, whatever ticks or channel state come after.
- R3: With `rnd_en_i` = 0, `tx_start_o` follows exactly 15 ticks counted from the start of the wait (10 fixed + 5 slots).
- R4: With `rnd_en_i` = 1, the number of ticks from the start of the wait to `tx_start_o` lies between 10 and 20 inclusive.
- R5: With `rnd_en_i` = 1, successive backoffs do not all use the same tick count.
- R6: If `cs_i` goes high during the wait, the countdown is abandoned. A fresh full wait starts when `cs_i` next falls, so with `rnd_en_i` = 0 exactly 15 ticks after that point are needed.
- R7: Time advances only on `tick_i` pulses. With no ticks, no `tx_start_o` occurs however many clock cycles pass.
- R8: `tx_start_o` is high for exactly one cycle, and `busy_o` is 0 in that cycle and the next.
- R9: Synchronous active-high `rst` forces `busy_o` = 0 and `tx_start_o` = 0, including when applied in the middle of a wait.
- R10: `busy_o` rises in the cycle after an accepted request and stays high until the cycle of `tx_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Carrier sense, 1 = channel busy |
| rssi_ok_i | input | 1 | Signal-strength reading is valid |
| tx_req_i | input | 1 | Transmit request strobe |
| rnd_en_i | input | 1 | 1 = random slot count, 0 = fixed 5 slots |
| tick_i | input | 1 | One-cycle 0.5 ms timebase pulse |
| clear_o | output | 1 | Clear-channel flag, inverse of carrier sense |
| tx_start_o | output | 1 | One-cycle transmit-start pulse |
| busy_o | output | 1 | Request pending (listening or counting) |

## Verification
The backoff is run with the random enable off and with different gaps before the channel clears. This shows that the 15-tick count does not depend on how long the block spent listening. Carrier bursts are injected early in the wait and on the last tick before completion. This separates a design that restarts from zero from one that resumes or ignores the burst. With the random enable on, several attempts launched at different cycle offsets must each land in 10..20 ticks and must not all match, which exposes a generator that is stuck or disabled. Separate directed runs cover:
- requests made while the signal-strength reading is invalid;
- long stretches of clock cycles with no ticks;
- a reset applied in the middle of a wait.

// File: rtl/lbt_pkg.sv
`timescale 1ns/1ps
package lbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LISTEN = 2'd1,
    ST_WAIT   = 2'd2
  } lbt_state_e;

  // One Fibonacci shift step: feedback is the parity of the tapped bits.
  function automatic logic [31:0] lfsr_step(logic [31:0] s, logic [31:0] taps,
                                            int unsigned w);
    logic        fb;
    logic [31:0] msk;
    fb  = ^(s & taps);
    msk = (w >= 32) ? '1 : ((32'd1 << w) - 32'd1);
    return ((s << 1) | {31'd0, fb}) & msk;
  endfunction

  // Fold a raw generator value into 0..top.
  function automatic int unsigned fold_slots(int unsigned raw, int unsigned top);
    return raw % (top + 1);
  endfunction

  // Ticks needed for one complete backoff.
  function automatic int unsigned total_ticks(int unsigned fixed_t, int unsigned slots);
    return fixed_t + slots;
  endfunction

endpackage

// File: rtl/lbt_slot_gen.sv
`timescale 1ns/1ps
module lbt_slot_gen
  import lbt_pkg::*;
#(
  parameter int unsigned    LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] TAPS   = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED   = 16'hACE1,
  parameter int unsigned    MAX_SLOTS = 10,
  parameter int unsigned    DEF_SLOTS = 5,
  localparam int unsigned   SLOT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rnd_en_i,
  output logic [SLOT_W-1:0] slots_o
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [SLOT_W-1:0] rand_slots;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= SEED;
    else     lfsr_q <= LFSR_W'(lfsr_step(32'(lfsr_q), 32'(TAPS), LFSR_W));
  end

  always_comb begin
    rand_slots = SLOT_W'(fold_slots(32'(lfsr_q), MAX_SLOTS));
    slots_o    = rnd_en_i ? rand_slots : SLOT_W'(DEF_SLOTS);
  end

  // R5
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

endmodule

// File: rtl/lbt_listen_timer.sv
`timescale 1ns/1ps
module lbt_listen_timer
  import lbt_pkg::*;
#(
  parameter int unsigned  FIXED_TICKS = 10,
  parameter int unsigned  MAX_SLOTS   = 10,
  localparam int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1),
  localparam int unsigned CNT_W       = $clog2(FIXED_TICKS + MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slots_i,
  output logic              done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] goal_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign done_o  = run_i && tick_i && (cnt_nxt == goal_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      goal_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      goal_q <= CNT_W'(total_ticks(FIXED_TICKS, 32'(slots_i)));
    end else if (run_i && tick_i) begin
      cnt_q  <= cnt_nxt;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !restart_i) |=> $stable(cnt_q));

  // R4
  goal_range_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (goal_q >= CNT_W'(FIXED_TICKS)) &&
                  (goal_q <= CNT_W'(FIXED_TICKS + MAX_SLOTS)));

endmodule

// File: rtl/lbt_seq.sv
`timescale 1ns/1ps
module lbt_seq
  import lbt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic rssi_ok_i,
  input  logic tx_req_i,
  input  logic done_i,
  output logic restart_o,
  output logic run_o,
  output logic tx_start_o,
  output logic busy_o
);

  lbt_state_e state_q, state_d;
  logic       tx_q;
  logic       finish_w;

  assign restart_o = (state_q == ST_LISTEN) && !cs_i;
  assign run_o     = (state_q == ST_WAIT) && !cs_i;
  assign finish_w  = run_o && done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (tx_req_i && rssi_ok_i) state_d = ST_LISTEN;
      ST_LISTEN: if (!cs_i)                 state_d = ST_WAIT;
      ST_WAIT: begin
        if (cs_i)          state_d = ST_LISTEN;
        else if (finish_w) state_d = ST_IDLE;
      end
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= finish_w;
    end
  end

  assign tx_start_o = tx_q;
  assign busy_o     = (state_q != ST_IDLE);

  // R2
  req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !rssi_ok_i) |=> (state_q == ST_IDLE));

  // R6
  abandon_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WAIT) && cs_i) |=> (state_q == ST_LISTEN) && !tx_start_o);

  // R8
  tx_one_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |=> !tx_start_o);

  // R8
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start_o |-> !busy_o);

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && tx_req_i && rssi_ok_i) |=> busy_o);

endmodule

// File: rtl/lbt_backoff.sv
`timescale 1ns/1ps
module lbt_backoff
  import lbt_pkg::*;
#(
  parameter int unsigned  FIXED_TICKS = 10,
  parameter int unsigned  MAX_SLOTS   = 10,
  parameter int unsigned  DEF_SLOTS   = 5,
  parameter int unsigned  LFSR_W      = 16,
  localparam int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic rssi_ok_i,
  input  logic tx_req_i,
  input  logic rnd_en_i,
  input  logic tick_i,
  output logic clear_o,
  output logic tx_start_o,
  output logic busy_o
);

  logic [SLOT_W-1:0] slots_w;
  logic              restart_w;
  logic              run_w;
  logic              done_w;

  assign clear_o = ~cs_i;

  lbt_slot_gen #(
    .LFSR_W   (LFSR_W),
    .MAX_SLOTS(MAX_SLOTS),
    .DEF_SLOTS(DEF_SLOTS)
  ) u_slots (
    .clk     (clk),
    .rst     (rst),
    .rnd_en_i(rnd_en_i),
    .slots_o (slots_w)
  );

  lbt_listen_timer #(
    .FIXED_TICKS(FIXED_TICKS),
    .MAX_SLOTS  (MAX_SLOTS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .restart_i(restart_w),
    .run_i    (run_w),
    .tick_i   (tick_i),
    .slots_i  (slots_w),
    .done_o   (done_w)
  );

  lbt_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs_i),
    .rssi_ok_i (rssi_ok_i),
    .tx_req_i  (tx_req_i),
    .done_i    (done_w),
    .restart_o (restart_w),
    .run_o     (run_w),
    .tx_start_o(tx_start_o),
    .busy_o    (busy_o)
  );

  // R1
  clear_run_chk: assert property (@(posedge clk) disable iff (rst)
    run_w |-> clear_o);

  // R3
  fixed_goal_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_w && !rnd_en_i) |=> (u_timer.goal_q == 5'(FIXED_TICKS + DEF_SLOTS)));

endmodule

// File: tb/lbt_backoff_test.sv
`timescale 1ns/1ps
module lbt_backoff_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b1, rssi_ok = 1'b1, tx_req = 1'b0, rnd_en = 1'b0, tick = 1'b0;
  logic clear_w, tx_start_w, busy_w;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lbt_backoff uut (
    .clk(clk), .rst(rst), .cs_i(cs), .rssi_ok_i(rssi_ok), .tx_req_i(tx_req),
    .rnd_en_i(rnd_en), .tick_i(tick), .clear_o(clear_w),
    .tx_start_o(tx_start_w), .busy_o(busy_w)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Issue one request, clear channel after gap, tick until tx_start.
  // brk>0: at that tick index a carrier burst replaces the tick and counting restarts.
  task automatic attempt(input bit rnd, input int gap, input int brk, output int ticks);
    int cnt = 0;
    bit seen = 0;
    rnd_en = rnd;
    cs = 1'b1;
    @(negedge clk); tx_req = 1'b1; rssi_ok = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(busy_w == 1'b1, "R10 busy after request", busy_w, 1);
    cycles(gap);
    cs = 1'b0;
    cycles(2);
    chk(clear_w == 1'b1, "R1 clear during wait", clear_w, 1);
    for (int k = 1; k <= 40 && !seen; k++) begin
      if (brk != 0 && k == brk) begin
        cs = 1'b1;
        cycles(3);
        chk(busy_w == 1'b1 && tx_start_w == 1'b0, "R6 still pending after burst", busy_w, 1);
        cs = 1'b0;
        cycles(2);
        cnt = 0;
      end
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      cnt++;
      if (tx_start_w) begin
        seen = 1;
        chk(busy_w == 1'b0, "R8 busy low at pulse", busy_w, 0);
        @(negedge clk);
        chk(tx_start_w == 1'b0 && busy_w == 1'b0, "R8 single pulse", tx_start_w, 0);
      end else begin
        chk(busy_w == 1'b1, "R10 busy held", busy_w, 1);
      end
    end
    ticks = seen ? cnt : -1;
    cycles(2);
  endtask

  // fields: rnd[24], gap[23:16], brk[15:8], expected ticks[7:0] (0 = random range)
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'd3,  8'd0,  8'd15},
    {1'b0, 8'd9,  8'd4,  8'd15},
    {1'b0, 8'd2,  8'd14, 8'd15},
    {1'b1, 8'd1,  8'd0,  8'd0},
    {1'b1, 8'd7,  8'd0,  8'd0},
    {1'b1, 8'd13, 8'd3,  8'd0},
    {1'b1, 8'd22, 8'd0,  8'd0},
    {1'b1, 8'd31, 8'd0,  8'd0}
  };

  initial begin
    int t;
    int first_rand = -1;
    bit varied = 0;

    cycles(3);
    chk(busy_w == 1'b0 && tx_start_w == 1'b0, "R9 reset state", busy_w, 0);
    rst = 1'b0;
    cycles(2);

    // R1: clear follows carrier sense
    cs = 1'b0; #1;
    chk(clear_w == 1'b1, "R1 clear when cs low", clear_w, 1);
    cs = 1'b1; #1;
    chk(clear_w == 1'b0, "R1 clear when cs high", clear_w, 0);
    cycles(1);

    for (int i = 0; i < NV; i++) begin
      attempt(VEC[i][24], int'(VEC[i][23:16]), int'(VEC[i][15:8]), t);
      if (VEC[i][7:0] != 0) begin
        if (VEC[i][15:8] != 0) chk(t == 15, "R6 fresh wait after burst", t, 15);
        else                   chk(t == 15, "R3 fixed backoff", t, 15);
      end else begin
        chk(t >= 10 && t <= 20, "R4 random backoff range", t, 15);
        if (first_rand < 0) first_rand = t;
        else if (t != first_rand) varied = 1;
      end
    end
    chk(varied, "R5 random counts vary", varied, 1);

    // R2: request with invalid signal strength is ignored
    rnd_en = 1'b0; cs = 1'b1;
    @(negedge clk); rssi_ok = 1'b0; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    chk(busy_w == 1'b0, "R2 request ignored busy", busy_w, 0);
    cs = 1'b0;
    t = 0;
    for (int k = 0; k < 25; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      if (tx_start_w || busy_w) t++;
      @(negedge clk);
    end
    chk(t == 0, "R2 no activity after ignored request", t, 0);
    rssi_ok = 1'b1;

    // R7: no ticks means no progress
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    t = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (tx_start_w) t++;
    end
    chk(t == 0 && busy_w == 1'b1, "R7 no pulse without ticks", t, 0);
    t = 0;
    for (int k = 1; k <= 20 && t == 0; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      if (tx_start_w) t = k;
    end
    chk(t == 15, "R7 R3 completes after ticks resume", t, 15);
    cycles(2);

    // R9: reset in mid-wait
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
    rst = 1'b1;
    @(negedge clk);
    chk(busy_w == 1'b0 && tx_start_w == 1'b0, "R9 reset mid-wait", busy_w, 0);
    rst = 1'b0;
    t = 0;
    for (int k = 0; k < 20; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      if (tx_start_w) t++;
    end
    chk(t == 0, "R9 no pending pulse after reset", t, 0);

    summary();
  end

endmodule